// File: doc/BRIEF.md
# Dual-Channel Interrupt and Output Port

This block is the shared part of a two-channel serial controller. It gathers the ready signals that each channel raises into one registered interrupt status byte. A host-written enable mask gates that byte, and the result drives an active-low interrupt request line. The channel logic itself sits outside this block and is represented only by its ready inputs.

The same register bus also serves a general output port and an input port. Output bits change only through two command addresses: one sets bits and the other clears them. Each bit written as 1 acts on the matching output, and bits written as 0 leave their outputs as they are. An output-routing byte can hand any output pin over to the matching interrupt status bit. The value 0 leaves every pin under the control of the set and clear commands. The input pins are active low and are read back inverted, so a pin held low reads as 1.

The host bus is byte wide. It has a 4-bit address, a write strobe and a read path that returns data in the same cycle.

Top module: `ioirq_top`

## Requirements
- R1: Status byte read at offset 5 has channel c transmitter ready at bit 4c and receiver ready at bit 4c+1; all other bits read 0; it reflects the ready inputs as sampled at the previous clock edge.
- R2: A write to offset 5 loads the interrupt enable mask; the mask resets to 0, so irq_n is 1 after reset whatever the ready inputs do.
- R3: irq_n is 0 exactly when the registered status AND the mask is nonzero, in the same cycle the status register updates.
- R4: A write to offset 0xE sets each output bit whose data bit is 1 and leaves the others unchanged.
- R5: A write to offset 0xF clears each output bit whose data bit is 1 and leaves the others unchanged.
- R6: The output pins are the inverse of the output bits (bit 1 drives pin low); the output bits reset to 0, so all pins are high after reset.
- R7: The routing byte is written at offset 0xD and resets to 0; where routing bit k is 1, pin k is driven by the inverse of status bit k instead of output bit k.
- R8: A read at offset 4 returns the inverted input pins sampled at the previous clock edge.
- R9: A write to offset 4 has no effect on the pins, the status read or irq_n, and reads at unmapped offsets return 0.
- R10: When a mask write and a change of ready input land on the same clock edge, irq_n right after that edge reflects both the new mask and the new status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe, acts at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |
| tx_rdy | input | 2 | Per-channel transmitter ready |
| rx_rdy | input | 2 | Per-channel receiver ready |
| in_pins | input | 8 | Active-low input pins |
| out_pins | output | 8 | Active-low output pins |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The two functions that can meet in the same cycle are the host's mask write and a change in a channel's ready input. Both are registered on the same edge and combine in the interrupt line. The bench raises a receiver ready input and writes a mask that enables only that bit, both in one cycle. It then drops the input and writes a zero mask, again in one cycle. In each case irq_n is judged in the cycle just after that edge against a value the bench works out from the new mask and the new status together. A design that used either stale value would show up there.

// File: rtl/ioirq_pkg.sv
package ioirq_pkg;
  localparam logic [3:0] OFS_INPORT = 4'h4;
  localparam logic [3:0] OFS_IRQ    = 4'h5;
  localparam logic [3:0] OFS_ROUTE  = 4'hD;
  localparam logic [3:0] OFS_OSET   = 4'hE;
  localparam logic [3:0] OFS_OCLR   = 4'hF;

  // status bit position of a channel's transmitter ready
  function automatic int tx_pos(input int ch, input int stride);
    return ch * stride;
  endfunction

  // status bit position of a channel's receiver ready
  function automatic int rx_pos(input int ch, input int stride);
    return ch * stride + 1;
  endfunction

  // next output bits after a set and/or clear command
  function automatic logic [7:0] op_update(input logic [7:0] cur, input logic set_en,
                                           input logic clr_en, input logic [7:0] d);
    logic [7:0] nxt;
    nxt = cur;
    if (set_en) nxt = nxt | d;
    if (clr_en) nxt = nxt & ~d;
    return nxt;
  endfunction
endpackage

// File: rtl/ioirq_status.sv
module ioirq_status #(
  parameter int NCH    = 2,
  parameter int STRIDE = 4,
  parameter int W      = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tx_rdy,
  input  logic [NCH-1:0] rx_rdy,
  input  logic           mask_we,
  input  logic [W-1:0]   mask_d,
  output logic [W-1:0]   stat_q,
  output logic [W-1:0]   mask_q,
  output logic           irq_n
);
  import ioirq_pkg::*;

  logic [W-1:0] stat_d;

  always_comb begin
    stat_d = '0;
    for (int c = 0; c < NCH; c++) begin
      stat_d[tx_pos(c, STRIDE)] = tx_rdy[c];
      stat_d[rx_pos(c, STRIDE)] = rx_rdy[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  assign irq_n = ~|(stat_q & mask_q);
endmodule

// File: rtl/ioirq_outport.sv
module ioirq_outport #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         route_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] alt_src,
  output logic [W-1:0] op_q,
  output logic [W-1:0] route_q,
  output logic [W-1:0] pins
);
  import ioirq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      route_q <= '0;
    end else begin
      op_q <= op_update(op_q, set_we, clr_we, wdata);
      if (route_we) route_q <= wdata;
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_pin
    assign pins[k] = route_q[k] ? ~alt_src[k] : ~op_q[k];
  end
endmodule

// File: rtl/ioirq_inport.sv
module ioirq_inport #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_in,
  output logic [W-1:0] level_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= ~pins_in;
  end
endmodule

// File: rtl/ioirq_top.sv
module ioirq_top #(
  parameter int NCH    = 2,
  parameter int STRIDE = 4,
  parameter int DW     = 8,
  parameter int AW     = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] tx_rdy,
  input  logic [NCH-1:0] rx_rdy,
  input  logic [DW-1:0]  in_pins,
  output logic [DW-1:0]  out_pins,
  output logic           irq_n
);
  import ioirq_pkg::*;

  localparam int STAT_W = NCH * STRIDE;

  // named decode events, used by the checker
  logic we_mask, we_set, we_clr, we_route;
  logic [DW-1:0] stat_q, mask_q, op_q, route_q, in_level;

  assign we_mask  = bus_we && (bus_addr == OFS_IRQ);
  assign we_set   = bus_we && (bus_addr == OFS_OSET);
  assign we_clr   = bus_we && (bus_addr == OFS_OCLR);
  assign we_route = bus_we && (bus_addr == OFS_ROUTE);

  if (STAT_W == DW) begin : g_stat_full
    ioirq_status #(.NCH(NCH), .STRIDE(STRIDE), .W(DW)) u_status (
      .clk(clk), .rst_n(rst_n), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
      .mask_we(we_mask), .mask_d(bus_wdata),
      .stat_q(stat_q), .mask_q(mask_q), .irq_n(irq_n));
  end else begin : g_stat_narrow
    logic [STAT_W-1:0] s_q, m_q;
    ioirq_status #(.NCH(NCH), .STRIDE(STRIDE), .W(STAT_W)) u_status (
      .clk(clk), .rst_n(rst_n), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
      .mask_we(we_mask), .mask_d(bus_wdata[STAT_W-1:0]),
      .stat_q(s_q), .mask_q(m_q), .irq_n(irq_n));
    assign stat_q = DW'(s_q);
    assign mask_q = DW'(m_q);
  end

  ioirq_outport #(.W(DW)) u_outport (
    .clk(clk), .rst_n(rst_n), .set_we(we_set), .clr_we(we_clr),
    .route_we(we_route), .wdata(bus_wdata), .alt_src(stat_q),
    .op_q(op_q), .route_q(route_q), .pins(out_pins));

  ioirq_inport #(.W(DW)) u_inport (
    .clk(clk), .rst_n(rst_n), .pins_in(in_pins), .level_q(in_level));

  always_comb begin
    unique case (bus_addr)
      OFS_IRQ:    bus_rdata = stat_q;
      OFS_INPORT: bus_rdata = in_level;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ioirq_checker.sv
module ioirq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       we_mask,
  input logic       we_set,
  input logic       we_clr,
  input logic [7:0] bus_wdata,
  input logic [1:0] tx_rdy,
  input logic [1:0] rx_rdy,
  input logic [7:0] stat_q,
  input logic [7:0] mask_q,
  input logic [7:0] op_q,
  input logic [7:0] route_q,
  input logic [7:0] out_pins,
  input logic       irq_n
);
  // R1: status follows ready inputs one edge later at stride-4 positions
  a_r1_status_layout: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q[0] == $past(tx_rdy[0])) && (stat_q[1] == $past(rx_rdy[0])) &&
             (stat_q[4] == $past(tx_rdy[1])) && (stat_q[5] == $past(rx_rdy[1])) &&
             ((stat_q & 8'hCC) == 8'h00));

  // R2: mask write loads the mask
  a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_mask |=> mask_q == $past(bus_wdata));

  // R4: set command only raises bits
  a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (we_set && !we_clr) |=> ((op_q & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((op_q & ~$past(bus_wdata)) == ($past(op_q) & ~$past(bus_wdata))));

  // R5: clear command only lowers bits
  a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (we_clr && !we_set) |=> ((op_q & $past(bus_wdata)) == 8'h00) &&
      ((op_q & ~$past(bus_wdata)) == ($past(op_q) & ~$past(bus_wdata))));

  // R6: without routing the pins are the inverted output bits
  a_r6_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == 8'h00) |-> out_pins == ~op_q);

  // R3: a low request line always has an enabled status bit behind it
  a_r3_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (stat_q & mask_q) != 8'h00);
endmodule

bind ioirq_top ioirq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .we_mask(we_mask), .we_set(we_set), .we_clr(we_clr),
  .bus_wdata(bus_wdata), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .stat_q(stat_q),
  .mask_q(mask_q), .op_q(op_q), .route_q(route_q), .out_pins(out_pins), .irq_n(irq_n));

// File: tb/ioirq_top_tb.sv
module ioirq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] tx_rdy = 2'b00;
  logic [1:0] rx_rdy = 2'b00;
  logic [7:0] in_pins = 8'hFF;
  logic [7:0] out_pins;
  logic       irq_n;

  always #5 clk = ~clk;

  ioirq_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_rdy(tx_rdy),
    .rx_rdy(rx_rdy), .in_pins(in_pins), .out_pins(out_pins), .irq_n(irq_n));

  typedef enum logic [1:0] {K_READ, K_IRQ, K_PINS} kind_e;
  typedef struct {
    kind_e kind;
    logic [7:0] exp;
    string tag;
  } item_t;

  item_t sbq[$];
  logic  pend = 1'b0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // model state kept by the bench
  logic [7:0] m_op = 8'h00;

  // monitor: pops one expectation per request, mid-cycle
  always @(negedge clk) begin
    if (pend) begin
      item_t it;
      logic [7:0] act;
      it = sbq.pop_front();
      case (it.kind)
        K_READ:  act = bus_rdata;
        K_IRQ:   act = {7'h0, irq_n};
        default: act = out_pins;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
      pend <= 1'b0;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic expect_item(input kind_e k, input logic [3:0] a, input logic [7:0] e,
                             input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.kind = k; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    pend = 1'b1;
    @(negedge clk); #1;
  endtask

  function automatic logic [7:0] stat_of(input logic [1:0] t, input logic [1:0] r);
    logic [7:0] s;
    s = 8'h00;
    for (int c = 0; c < 2; c++) begin
      s[4*c]   = t[c];
      s[4*c+1] = r[c];
    end
    return s;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    expect_item(K_READ, 4'h5, 8'h00, "R1 status after reset");
    expect_item(K_IRQ, 4'h0, 8'h01, "R2 irq_n idle after reset");
    expect_item(K_PINS, 4'h0, 8'hFF, "R6 pins high after reset");
    expect_item(K_READ, 4'h4, 8'h00, "R8 inputs idle read 0");

    // status layout, mask still 0
    tx_rdy = 2'b01;
    expect_item(K_READ, 4'h5, stat_of(2'b01, 2'b00), "R1 tx ch0 at bit 0");
    expect_item(K_IRQ, 4'h0, 8'h01, "R2 zero mask holds irq_n high");
    rx_rdy = 2'b10;
    expect_item(K_READ, 4'h5, stat_of(2'b01, 2'b10), "R1 rx ch1 at bit 5");

    // mask gating
    wr(4'h5, 8'h20);
    expect_item(K_IRQ, 4'h0, 8'h00, "R3 enabled rx ch1 asserts irq");
    wr(4'h5, 8'h02);
    expect_item(K_IRQ, 4'h0, 8'h01, "R3 disabled bit releases irq");
    wr(4'h5, 8'h00);

    // same-edge mask write and ready change
    @(posedge clk); #1;
    bus_addr = 4'h5; bus_we = 1'b1; bus_wdata = 8'h02; rx_rdy[0] = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
    sbq.push_back('{K_IRQ, 8'h00, "R10 new mask with new status asserts"});
    pend = 1'b1;
    @(negedge clk); #1;
    @(posedge clk); #1;
    bus_addr = 4'h5; bus_we = 1'b1; bus_wdata = 8'h00; rx_rdy[0] = 1'b0;
    @(posedge clk); #1;
    bus_we = 1'b0;
    sbq.push_back('{K_IRQ, 8'h01, "R10 zero mask with dropped status releases"});
    pend = 1'b1;
    @(negedge clk); #1;

    // output port set / clear
    wr(4'hE, 8'h0F); m_op = m_op | 8'h0F;
    expect_item(K_PINS, 4'h0, ~m_op, "R4 set low nibble");
    wr(4'hE, 8'h30); m_op = m_op | 8'h30;
    expect_item(K_PINS, 4'h0, ~m_op, "R4 set keeps other bits");
    wr(4'hF, 8'h05); m_op = m_op & ~8'h05;
    expect_item(K_PINS, 4'h0, ~m_op, "R5 clear selected bits");
    wr(4'hF, 8'h00);
    expect_item(K_PINS, 4'h0, ~m_op, "R5 clear with zero data no change");

    // routing: pin0 follows inverse of status bit0 (tx ch0 = 1)
    wr(4'hD, 8'h01);
    expect_item(K_PINS, 4'h0, {~m_op[7:1], ~stat_of(tx_rdy, rx_rdy)[0]}, "R7 pin0 routed to status");
    tx_rdy[0] = 1'b0;
    expect_item(K_PINS, 4'h0, {~m_op[7:1], 1'b1}, "R7 routed pin tracks status");
    wr(4'hD, 8'h00);
    expect_item(K_PINS, 4'h0, ~m_op, "R7 routing off restores output bit");

    // input port
    in_pins = 8'hA5;
    expect_item(K_READ, 4'h4, 8'h5A, "R8 inverted input read");

    // ignored write and unmapped reads
    wr(4'h4, 8'hFF);
    expect_item(K_PINS, 4'h0, ~m_op, "R9 write to input offset leaves pins");
    expect_item(K_READ, 4'h5, stat_of(tx_rdy, rx_rdy), "R9 write to input offset leaves status");
    expect_item(K_IRQ, 4'h0, 8'h01, "R9 write to input offset leaves irq");
    expect_item(K_READ, 4'h7, 8'h00, "R9 unmapped read is 0");
    expect_item(K_READ, 4'hE, 8'h00, "R9 command offset reads 0");

    repeat (2) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule